// File: doc/BRIEF.md
# USB PHY Power-Up Sequencer

This block is a hardware state machine that brings a combined USB 2 / USB 3 PHY and its controller out of reset in a fixed order and shuts the PHY down again. It takes the place of a software bring-up routine. A single start pulse puts every reset back in its asserted state. The machine then selects the reference clock from a strap and takes the USB 2 PHY out of IDDQ and the USB 3 PHY out of test power-down. After that it releases the PHY resets, waits a settle time, and raises the power-stable flags. It then configures the type-C mux, turns on spread spectrum, releases the controller resets and forces the VBUS-valid overrides. Timed settle waits sit between these steps.

The last step is a read-modify-write of the PHY's transmit-boost register over a simple control-bus master port. The sequencer sets the boost enable bit and ORs in a boost level. A read that times out is retried. Any other bus error, and any timeout on the write, ends the sequence in a latched error. A stop pulse puts the PHY back into reset and removes the reference clock that was chosen at start. The sequencer accepts a stop only after the sequence has finished, whether in done or in error.

Top module: `usb_phy_pwrup_seq`

## Requirements
- R1: Out of reset all four reset-release outputs are 0, `u2_iddq_o`, `u3_testpd_o` and `mux_lowpwr_o` are 1, and every other output, including busy, done and error, is 0.
- R2: A start pulse seen while idle, done or in error drives all four reset-release outputs to 0, sets busy, and clears done and error in the same cycle. Start and stop pulses seen while busy are ignored. Start wins over stop when both arrive together.
- R3: At clock selection the strap is sampled. With `clk_src_pad_i`=1 the sequencer sets `pad_clk_sel_o` and `pad_clk_gate_o`. With 0 it clears `pad_clk_sel_o` and sets `osc_iso_off_o` and `osc_en_o`.
- R4: Each of the following steps takes effect on its own later clock edge, in this order: clock selection, IDDQ cleared, test power-down cleared, then USB3 PHY reset and USB2 power-on reset released together.
- R5: At least WAIT_CYC cycles, where WAIT_CYC = CLK_HZ/1e6 × WAIT_US, pass between the PHY reset release and the moment all three `pwr_stable_o` bits (0 analog power, 1 PCS, 2 PMA) rise together.
- R6: After the power flags, mux setup happens on one edge. `mux_irq_clr_o` pulses for exactly one cycle, and on the same edge `mux_irq_en_o` becomes 2'b11, `mux_valid_o` becomes 1, `mux_lowpwr_o` becomes 0 and `mux_ovr_o` becomes 2'b11. On the next edge `ssc_en_o` rises, and on the edge after that the auxiliary and controller resets are released.
- R7: At least WAIT_CYC cycles after the controller reset release, both `vbus_force_o` bits (0 USB3, 1 USB2) rise. At least WAIT_CYC cycles after that, the first bus request is issued.
- R8: The bus master holds `bus_req_o`, `bus_we_o`, `bus_addr_o` and `bus_wdata_o` steady until a one-cycle response arrives. Response priority is err over timeout over ack. It reads address 0xF and then writes `rdata | (1<<9) | (BOOST_LVL<<6)`, with a default level of 5. The write ack sets done and clears busy.
- R9: A read timeout causes the read to be reissued, for at most RD_TRIES=3 read attempts in total. If all attempts time out, the sequencer sets error and issues no write.
- R10: A bus error on the read or the write, or a timeout on the write, sets error at once and clears busy. No further request follows.
- R11: A stop pulse is honoured only while done or in error. Busy is set and done is cleared. On the next edge both PHY reset releases return to 0. On the edge after that, busy clears and either `pad_clk_gate_o` (if the pad clock was selected at start) or `osc_en_o` is cleared. The strap value at stop time plays no part. A stop pulse while idle changes nothing.
- R12: The error flag stays set through a stop and is cleared only by the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start power-up pulse |
| stop_i | input | 1 | Shutdown request pulse |
| clk_src_pad_i | input | 1 | Strap: 1 pad reference clock, 0 internal oscillator |
| aux_rst_rel_o | output | 1 | Auxiliary reset released |
| ctl_rst_rel_o | output | 1 | Controller reset released |
| u3phy_rst_rel_o | output | 1 | USB3 PHY reset released |
| u2_por_rel_o | output | 1 | USB2 PHY power-on reset released |
| pad_clk_sel_o | output | 1 | Reference clock taken from pad |
| pad_clk_gate_o | output | 1 | Pad reference clock gate enable |
| osc_en_o | output | 1 | Internal oscillator enable |
| osc_iso_off_o | output | 1 | Oscillator path isolation removed |
| u2_iddq_o | output | 1 | USB2 PHY IDDQ control |
| u3_testpd_o | output | 1 | USB3 PHY test power-down |
| pwr_stable_o | output | 3 | Analog power enable, PCS stable, PMA stable |
| mux_irq_clr_o | output | 1 | One-cycle clear of pending mux interrupts |
| mux_irq_en_o | output | 2 | Mux ack / timeout interrupt enables |
| mux_valid_o | output | 1 | Mux setting valid, USB-only routing |
| mux_lowpwr_o | output | 1 | Mux low-power request |
| mux_ovr_o | output | 2 | Mux VBUS-valid / power-present overrides |
| ssc_en_o | output | 1 | Spread-spectrum enable |
| vbus_force_o | output | 2 | Forced VBUS valid, USB3 and USB2 |
| bus_req_o | output | 1 | Control-bus request |
| bus_we_o | output | 1 | Control-bus write (1) / read (0) |
| bus_addr_o | output | AW | Control-bus register address |
| bus_wdata_o | output | DW | Control-bus write data |
| bus_rdata_i | input | DW | Control-bus read data, valid with ack |
| bus_ack_i | input | 1 | Transaction completed |
| bus_timeout_i | input | 1 | Transaction timed out |
| bus_err_i | input | 1 | Transaction failed |
| busy_o | output | 1 | Sequence or shutdown in progress |
| done_o | output | 1 | Power-up finished |
| err_o | output | 1 | Power-up failed (latched) |

## Verification
The hardest situations to reach from the ports are the ones that depend on the bus responses. These include a read that times out once or twice and then succeeds, a read that times out on every attempt, and an error that arrives on the write rather than the read. A programmable bus responder in the bench counts read attempts in each run and answers each transaction from a per-run setting, so every retry and abort path can be driven on purpose. To show that shutdown uses the clock source chosen at start and not the live strap, the bench flips the strap just before a stop. To show that pulses arriving mid-sequence change nothing, the bench injects start and stop inside a settle wait. In both cases a scoreboard of output snapshots catches any extra or reordered step.

// File: rtl/upseq_pkg.sv
package upseq_pkg;

  typedef enum logic [4:0] {
    ST_IDLE, ST_CLKSEL, ST_IDDQ, ST_TPD, ST_PHYREL, ST_WAIT1, ST_PWRSTB,
    ST_MUXCFG, ST_SSC, ST_CTLREL, ST_WAIT2, ST_VBUS, ST_WAIT3, ST_RMW,
    ST_DONE, ST_ERR, ST_SD_RST, ST_SD_CLK
  } seq_state_t;

  typedef enum logic [1:0] {
    RM_IDLE, RM_READ, RM_WRITE
  } rmw_state_t;

endpackage

// File: rtl/upseq_settle_timer.sv
module upseq_settle_timer #(
  parameter int unsigned CYCLES = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic go,
  output logic expired
);
  localparam int unsigned TW = (CYCLES > 1) ? $clog2(CYCLES) : 1;

  logic [TW-1:0] cnt;
  logic          run;

  always_ff @(posedge clk) begin
    if (rst) begin
      run <= 1'b0;
      cnt <= '0;
    end else if (go) begin
      run <= 1'b1;
      cnt <= TW'(CYCLES - 1);
    end else if (run) begin
      if (cnt == '0) run <= 1'b0;
      else           cnt <= cnt - 1'b1;
    end
  end

  assign expired = run && (cnt == '0);

  AST_TMR_NO_EARLY_END: assert property (@(posedge clk) disable iff (rst)
    (run && cnt != '0 && !go) |=> run); // R5

endmodule

// File: rtl/upseq_reg_rmw.sv
module upseq_reg_rmw
  import upseq_pkg::*;
#(
  parameter int unsigned AW       = 16,
  parameter int unsigned DW       = 16,
  parameter int unsigned REG_ADDR = 15,
  parameter int unsigned EN_BIT   = 9,
  parameter int unsigned LVL_LSB  = 6,
  parameter int unsigned LVL_W    = 3,
  parameter int unsigned LVL      = 5,
  parameter int unsigned TRIES    = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  output logic          bus_req_o,
  output logic          bus_we_o,
  output logic [AW-1:0] bus_addr_o,
  output logic [DW-1:0] bus_wdata_o,
  input  logic [DW-1:0] bus_rdata_i,
  input  logic          bus_ack_i,
  input  logic          bus_timeout_i,
  input  logic          bus_err_i,
  output logic          ok_o,
  output logic          fail_o
);
  localparam int unsigned TCW = $clog2(TRIES + 1);
  localparam logic [DW-1:0] SET_MASK =
    (DW'(1) << EN_BIT) | (DW'(LVL % (1 << LVL_W)) << LVL_LSB);

  rmw_state_t     st;
  logic [TCW-1:0] tries;

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= RM_IDLE;
      bus_req_o   <= 1'b0;
      bus_we_o    <= 1'b0;
      bus_addr_o  <= '0;
      bus_wdata_o <= '0;
      tries       <= '0;
      ok_o        <= 1'b0;
      fail_o      <= 1'b0;
    end else begin
      ok_o   <= 1'b0;
      fail_o <= 1'b0;
      case (st)
        RM_IDLE: if (go) begin
          st         <= RM_READ;
          bus_req_o  <= 1'b1;
          bus_we_o   <= 1'b0;
          bus_addr_o <= AW'(REG_ADDR);
          tries      <= TCW'(1);
        end
        RM_READ: begin
          if (bus_err_i) begin
            bus_req_o <= 1'b0;
            fail_o    <= 1'b1;
            st        <= RM_IDLE;
          end else if (bus_timeout_i) begin
            if (tries == TCW'(TRIES)) begin
              bus_req_o <= 1'b0;
              fail_o    <= 1'b1;
              st        <= RM_IDLE;
            end else begin
              tries <= tries + 1'b1;
            end
          end else if (bus_ack_i) begin
            bus_we_o    <= 1'b1;
            bus_wdata_o <= bus_rdata_i | SET_MASK;
            st          <= RM_WRITE;
          end
        end
        RM_WRITE: begin
          if (bus_err_i || bus_timeout_i) begin
            bus_req_o <= 1'b0;
            bus_we_o  <= 1'b0;
            fail_o    <= 1'b1;
            st        <= RM_IDLE;
          end else if (bus_ack_i) begin
            bus_req_o <= 1'b0;
            bus_we_o  <= 1'b0;
            ok_o      <= 1'b1;
            st        <= RM_IDLE;
          end
        end
        default: st <= RM_IDLE;
      endcase
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (bus_req_o && !(bus_ack_i || bus_timeout_i || bus_err_i)) |=>
      (bus_req_o && $stable(bus_we_o) && $stable(bus_addr_o) && $stable(bus_wdata_o))); // R8
  AST_WR_MASK: assert property (@(posedge clk) disable iff (rst)
    (bus_req_o && bus_we_o) |-> ((bus_wdata_o & SET_MASK) == SET_MASK)); // R8
  AST_OK_FAIL_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(ok_o && fail_o)); // R10

endmodule

// File: rtl/usb_phy_pwrup_seq.sv
module usb_phy_pwrup_seq
  import upseq_pkg::*;
#(
  parameter int unsigned CLK_HZ       = 250_000_000,
  parameter int unsigned WAIT_US      = 100,
  parameter int unsigned AW           = 16,
  parameter int unsigned DW           = 16,
  parameter int unsigned BOOST_ADDR   = 15,
  parameter int unsigned BOOST_EN_BIT = 9,
  parameter int unsigned BOOST_LSB    = 6,
  parameter int unsigned BOOST_W      = 3,
  parameter int unsigned BOOST_LVL    = 5,
  parameter int unsigned RD_TRIES     = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic          clk_src_pad_i,
  output logic          aux_rst_rel_o,
  output logic          ctl_rst_rel_o,
  output logic          u3phy_rst_rel_o,
  output logic          u2_por_rel_o,
  output logic          pad_clk_sel_o,
  output logic          pad_clk_gate_o,
  output logic          osc_en_o,
  output logic          osc_iso_off_o,
  output logic          u2_iddq_o,
  output logic          u3_testpd_o,
  output logic [2:0]    pwr_stable_o,
  output logic          mux_irq_clr_o,
  output logic [1:0]    mux_irq_en_o,
  output logic          mux_valid_o,
  output logic          mux_lowpwr_o,
  output logic [1:0]    mux_ovr_o,
  output logic          ssc_en_o,
  output logic [1:0]    vbus_force_o,
  output logic          bus_req_o,
  output logic          bus_we_o,
  output logic [AW-1:0] bus_addr_o,
  output logic [DW-1:0] bus_wdata_o,
  input  logic [DW-1:0] bus_rdata_i,
  input  logic          bus_ack_i,
  input  logic          bus_timeout_i,
  input  logic          bus_err_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          err_o
);
  localparam int unsigned WAIT_CYC = (CLK_HZ / 1_000_000) * WAIT_US;
  localparam int unsigned AGW      = $clog2(WAIT_CYC + 2);

  seq_state_t state;
  logic       tmr_go, tmr_expired;
  logic       rmw_go, rmw_ok, rmw_fail;

  assign tmr_go = (state == ST_PHYREL) || (state == ST_CTLREL) || (state == ST_VBUS);
  assign rmw_go = (state == ST_WAIT3) && tmr_expired;

  upseq_settle_timer #(.CYCLES(WAIT_CYC)) u_timer (
    .clk(clk), .rst(rst), .go(tmr_go), .expired(tmr_expired)
  );

  upseq_reg_rmw #(
    .AW(AW), .DW(DW), .REG_ADDR(BOOST_ADDR), .EN_BIT(BOOST_EN_BIT),
    .LVL_LSB(BOOST_LSB), .LVL_W(BOOST_W), .LVL(BOOST_LVL), .TRIES(RD_TRIES)
  ) u_rmw (
    .clk(clk), .rst(rst), .go(rmw_go),
    .bus_req_o(bus_req_o), .bus_we_o(bus_we_o), .bus_addr_o(bus_addr_o),
    .bus_wdata_o(bus_wdata_o), .bus_rdata_i(bus_rdata_i), .bus_ack_i(bus_ack_i),
    .bus_timeout_i(bus_timeout_i), .bus_err_i(bus_err_i),
    .ok_o(rmw_ok), .fail_o(rmw_fail)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state           <= ST_IDLE;
      aux_rst_rel_o   <= 1'b0;
      ctl_rst_rel_o   <= 1'b0;
      u3phy_rst_rel_o <= 1'b0;
      u2_por_rel_o    <= 1'b0;
      pad_clk_sel_o   <= 1'b0;
      pad_clk_gate_o  <= 1'b0;
      osc_en_o        <= 1'b0;
      osc_iso_off_o   <= 1'b0;
      u2_iddq_o       <= 1'b1;
      u3_testpd_o     <= 1'b1;
      pwr_stable_o    <= '0;
      mux_irq_clr_o   <= 1'b0;
      mux_irq_en_o    <= '0;
      mux_valid_o     <= 1'b0;
      mux_lowpwr_o    <= 1'b1;
      mux_ovr_o       <= '0;
      ssc_en_o        <= 1'b0;
      vbus_force_o    <= '0;
      busy_o          <= 1'b0;
      done_o          <= 1'b0;
      err_o           <= 1'b0;
    end else begin
      mux_irq_clr_o <= 1'b0;
      case (state)
        ST_IDLE, ST_DONE, ST_ERR: begin
          if (start_i) begin
            aux_rst_rel_o   <= 1'b0;
            ctl_rst_rel_o   <= 1'b0;
            u3phy_rst_rel_o <= 1'b0;
            u2_por_rel_o    <= 1'b0;
            busy_o          <= 1'b1;
            done_o          <= 1'b0;
            err_o           <= 1'b0;
            state           <= ST_CLKSEL;
          end else if (stop_i && state != ST_IDLE) begin
            busy_o <= 1'b1;
            done_o <= 1'b0;
            state  <= ST_SD_RST;
          end
        end
        ST_CLKSEL: begin
          if (clk_src_pad_i) begin
            pad_clk_sel_o  <= 1'b1;
            pad_clk_gate_o <= 1'b1;
          end else begin
            pad_clk_sel_o <= 1'b0;
            osc_iso_off_o <= 1'b1;
            osc_en_o      <= 1'b1;
          end
          state <= ST_IDDQ;
        end
        ST_IDDQ: begin
          u2_iddq_o <= 1'b0;
          state     <= ST_TPD;
        end
        ST_TPD: begin
          u3_testpd_o <= 1'b0;
          state       <= ST_PHYREL;
        end
        ST_PHYREL: begin
          u3phy_rst_rel_o <= 1'b1;
          u2_por_rel_o    <= 1'b1;
          state           <= ST_WAIT1;
        end
        ST_WAIT1: if (tmr_expired) state <= ST_PWRSTB;
        ST_PWRSTB: begin
          pwr_stable_o <= 3'b111;
          state        <= ST_MUXCFG;
        end
        ST_MUXCFG: begin
          mux_irq_clr_o <= 1'b1;
          mux_irq_en_o  <= 2'b11;
          mux_valid_o   <= 1'b1;
          mux_lowpwr_o  <= 1'b0;
          mux_ovr_o     <= 2'b11;
          state         <= ST_SSC;
        end
        ST_SSC: begin
          ssc_en_o <= 1'b1;
          state    <= ST_CTLREL;
        end
        ST_CTLREL: begin
          aux_rst_rel_o <= 1'b1;
          ctl_rst_rel_o <= 1'b1;
          state         <= ST_WAIT2;
        end
        ST_WAIT2: if (tmr_expired) state <= ST_VBUS;
        ST_VBUS: begin
          vbus_force_o <= 2'b11;
          state        <= ST_WAIT3;
        end
        ST_WAIT3: if (tmr_expired) state <= ST_RMW;
        ST_RMW: begin
          if (rmw_ok) begin
            done_o <= 1'b1;
            busy_o <= 1'b0;
            state  <= ST_DONE;
          end else if (rmw_fail) begin
            err_o  <= 1'b1;
            busy_o <= 1'b0;
            state  <= ST_ERR;
          end
        end
        ST_SD_RST: begin
          u3phy_rst_rel_o <= 1'b0;
          u2_por_rel_o    <= 1'b0;
          state           <= ST_SD_CLK;
        end
        ST_SD_CLK: begin
          if (pad_clk_sel_o) pad_clk_gate_o <= 1'b0;
          else               osc_en_o       <= 1'b0;
          busy_o <= 1'b0;
          state  <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Checker: cycles since the PHY resets were released (saturating)
  logic [AGW-1:0] rel_age;
  always_ff @(posedge clk) begin
    if (rst || !u3phy_rst_rel_o)          rel_age <= '0;
    else if (rel_age != AGW'(WAIT_CYC + 1)) rel_age <= rel_age + 1'b1;
  end

  AST_PWR_AFTER_WAIT: assert property (@(posedge clk) disable iff (rst)
    $rose(pwr_stable_o[0]) |-> (rel_age >= AGW'(WAIT_CYC))); // R5
  AST_PWR_AFTER_PD_EXIT: assert property (@(posedge clk) disable iff (rst)
    $rose(pwr_stable_o[0]) |-> (!u2_iddq_o && !u3_testpd_o && u2_por_rel_o)); // R4
  AST_CTL_ORDER: assert property (@(posedge clk) disable iff (rst)
    $rose(ctl_rst_rel_o) |-> (u3phy_rst_rel_o && (&pwr_stable_o) && ssc_en_o && mux_valid_o)); // R6
  AST_VBUS_ORDER: assert property (@(posedge clk) disable iff (rst)
    $rose(vbus_force_o[0]) |-> (aux_rst_rel_o && ctl_rst_rel_o)); // R7
  AST_STATUS_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(done_o && err_o) && !(busy_o && done_o)); // R2

endmodule

// File: tb/tb_usb_phy_pwrup_seq.sv
module tb_usb_phy_pwrup_seq;
  localparam int unsigned WAIT_CYC = 20;
  localparam int unsigned AW = 16;
  localparam int unsigned DW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0, stop_i = 1'b0, strap = 1'b1;
  logic aux_rel, ctl_rel, u3_rel, u2_rel, psel, pgate, osc, iso, iddq, tpd;
  logic [2:0] pwr;
  logic clr, mval, mlp, ssc, busy, done, err;
  logic [1:0] ien, movr, vb;
  logic bus_req, bus_we;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata;
  logic [DW-1:0] bus_rdata = '0;
  logic bus_ack = 1'b0, bus_to = 1'b0, bus_err = 1'b0;

  always #2 clk = ~clk;

  usb_phy_pwrup_seq #(.CLK_HZ(1_000_000), .WAIT_US(WAIT_CYC)) dut (
    .clk(clk), .rst(rst), .start_i(start_i), .stop_i(stop_i), .clk_src_pad_i(strap),
    .aux_rst_rel_o(aux_rel), .ctl_rst_rel_o(ctl_rel), .u3phy_rst_rel_o(u3_rel),
    .u2_por_rel_o(u2_rel), .pad_clk_sel_o(psel), .pad_clk_gate_o(pgate),
    .osc_en_o(osc), .osc_iso_off_o(iso), .u2_iddq_o(iddq), .u3_testpd_o(tpd),
    .pwr_stable_o(pwr), .mux_irq_clr_o(clr), .mux_irq_en_o(ien), .mux_valid_o(mval),
    .mux_lowpwr_o(mlp), .mux_ovr_o(movr), .ssc_en_o(ssc), .vbus_force_o(vb),
    .bus_req_o(bus_req), .bus_we_o(bus_we), .bus_addr_o(bus_addr), .bus_wdata_o(bus_wdata),
    .bus_rdata_i(bus_rdata), .bus_ack_i(bus_ack), .bus_timeout_i(bus_to), .bus_err_i(bus_err),
    .busy_o(busy), .done_o(done), .err_o(err)
  );

  int checks = 0, errors = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  // ---------------- bus responder ----------------
  int cfg_rd_to = 0;
  bit cfg_rd_err = 0, cfg_wr_to = 0;
  logic [DW-1:0] cfg_rdata = '0;
  int n_rd = 0, n_wr = 0, rd_seq = 0, lat = 0;
  logic [DW-1:0] last_wdata = '0;
  logic [AW-1:0] last_rd_addr = '0;

  always @(negedge clk) begin
    bus_ack = 1'b0; bus_to = 1'b0; bus_err = 1'b0;
    if (!busy) rd_seq = 0;
    if (rst || !bus_req) lat = 0;
    else if (lat < 2) lat++;
    else begin
      lat = 0;
      if (!bus_we) begin
        n_rd++; last_rd_addr = bus_addr;
        if (cfg_rd_err) bus_err = 1'b1;
        else if (rd_seq < cfg_rd_to) bus_to = 1'b1;
        else begin bus_ack = 1'b1; bus_rdata = cfg_rdata; end
        rd_seq++;
      end else begin
        n_wr++; last_wdata = bus_wdata;
        if (cfg_wr_to) bus_to = 1'b1; else bus_ack = 1'b1;
      end
    end
  end

  // ---------------- expected model + scoreboard ----------------
  logic e_aux = 0, e_ctl = 0, e_u3 = 0, e_u2 = 0, e_psel = 0, e_pgate = 0, e_osc = 0, e_iso = 0;
  logic e_iddq = 1, e_tpd = 1, e_clr = 0, e_mval = 0, e_mlp = 1, e_ssc = 0;
  logic e_busy = 0, e_done = 0, e_err = 0;
  logic [2:0] e_pwr = 0;
  logic [1:0] e_ien = 0, e_movr = 0, e_vb = 0;
  logic [25:0] exp_q[$];
  logic [25:0] last_pushed;

  function automatic logic [25:0] exp_snap();
    return {e_aux, e_ctl, e_u3, e_u2, e_psel, e_pgate, e_osc, e_iso, e_iddq, e_tpd,
            e_pwr, e_clr, e_ien, e_mval, e_mlp, e_movr, e_ssc, e_vb, e_busy, e_done, e_err};
  endfunction
  function automatic logic [25:0] dut_snap();
    return {aux_rel, ctl_rel, u3_rel, u2_rel, psel, pgate, osc, iso, iddq, tpd,
            pwr, clr, ien, mval, mlp, movr, ssc, vb, busy, done, err};
  endfunction

  task automatic push_exp();
    logic [25:0] s;
    s = exp_snap();
    if (s != last_pushed) begin exp_q.push_back(s); last_pushed = s; end
  endtask

  // monitor
  bit mon_on = 0;
  int cyc = 0, clr_cnt = 0;
  int t_u3r = 0, t_pwrr = 0, t_ctlr = 0, t_vbr = 0, t_reqr = 0;
  logic [25:0] prev;
  logic prev_req = 0;

  always @(negedge clk) begin
    logic [25:0] cur;
    logic [25:0] e;
    cyc++;
    if (mon_on) begin
      cur = dut_snap();
      if (clr) clr_cnt++;
      if (u3_rel && !prev[23]) t_u3r = cyc;
      if (pwr[0] && !prev[13]) t_pwrr = cyc;
      if (ctl_rel && !prev[24]) t_ctlr = cyc;
      if (vb[0] && !prev[3]) t_vbr = cyc;
      if (bus_req && !prev_req) t_reqr = cyc;
      prev_req = bus_req;
      if (cur != prev) begin
        if (exp_q.size() == 0) chk(0, "R4", "unexpected output step (R2 R11)", 32'(cur), 32'(prev));
        else begin
          e = exp_q.pop_front();
          chk(cur == e, "R4", "output step order (R6 R7 R11)", 32'(cur), 32'(e));
        end
        prev = cur;
      end
    end
  end

  // ---------------- driver tasks ----------------
  task automatic pulse(input bit is_start);
    @(negedge clk);
    if (is_start) start_i = 1'b1; else stop_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0; stop_i = 1'b0;
  endtask

  task automatic expect_run(input bit pad, input bit ok);
    e_aux = 0; e_ctl = 0; e_u3 = 0; e_u2 = 0; e_busy = 1; e_done = 0; e_err = 0; push_exp();
    if (pad) begin e_psel = 1; e_pgate = 1; end
    else begin e_psel = 0; e_iso = 1; e_osc = 1; end
    push_exp();
    e_iddq = 0; push_exp();
    e_tpd = 0; push_exp();
    e_u3 = 1; e_u2 = 1; push_exp();
    e_pwr = 3'b111; push_exp();
    e_clr = 1; e_ien = 2'b11; e_mval = 1; e_mlp = 0; e_movr = 2'b11; push_exp();
    e_clr = 0; e_ssc = 1; push_exp();
    e_aux = 1; e_ctl = 1; push_exp();
    e_vb = 2'b11; push_exp();
    e_busy = 0; if (ok) e_done = 1; else e_err = 1; push_exp();
  endtask

  task automatic expect_stop();
    e_busy = 1; e_done = 0; push_exp();
    e_u3 = 0; e_u2 = 0; push_exp();
    if (e_psel) e_pgate = 0; else e_osc = 0;
    e_busy = 0; push_exp();
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  int rd0, wr0, c0;

  initial begin
    last_pushed = exp_snap();
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(dut_snap() == exp_snap(), "R1", "reset outputs", 32'(dut_snap()), 32'(exp_snap()));
    chk(bus_req == 1'b0, "R1", "bus idle after reset", 32'(bus_req), 0);
    prev = dut_snap();
    mon_on = 1;

    // S2: pad clock, clean read-modify-write
    strap = 1; cfg_rdata = 16'h0000; cfg_rd_to = 0;
    rd0 = n_rd; wr0 = n_wr; c0 = clr_cnt;
    expect_run(1, 1);
    pulse(1);
    wait_idle();
    chk(psel && pgate && !osc, "R3", "pad path {sel,gate,osc}", {psel, pgate, osc}, 3'b110);
    chk(t_pwrr - t_u3r >= WAIT_CYC, "R5", "release to power-stable gap", t_pwrr - t_u3r, WAIT_CYC);
    chk(clr_cnt - c0 == 1, "R6", "irq clear pulse length", clr_cnt - c0, 1);
    chk(ien == 2'b11 && mval && !mlp && movr == 2'b11 && ssc, "R6", "mux setup",
        {ien, mval, mlp, movr, ssc}, 7'b1110111);
    chk(t_vbr - t_ctlr >= WAIT_CYC, "R7", "ctl release to vbus gap", t_vbr - t_ctlr, WAIT_CYC);
    chk(t_reqr - t_vbr >= WAIT_CYC, "R7", "vbus to bus request gap", t_reqr - t_vbr, WAIT_CYC);
    chk(last_rd_addr == 16'h000F, "R8", "read address", last_rd_addr, 16'h000F);
    chk(last_wdata == 16'h0340, "R8", "write-back value", last_wdata, 16'h0340);
    chk(n_rd - rd0 == 1 && n_wr - wr0 == 1, "R8", "reads*16+writes", (n_rd - rd0) * 16 + (n_wr - wr0), 17);
    chk(done && !err, "R8", "done after write ack", {done, err}, 2'b10);

    // S3: strap flipped before stop; shutdown uses clock chosen at start
    strap = 0;
    expect_stop();
    pulse(0);
    wait_idle();
    chk(!pgate && !u3_rel && !u2_rel && !busy && !done, "R11", "pad shutdown",
        {pgate, u3_rel, u2_rel, busy, done}, 0);

    // S4: oscillator path, two read timeouts, start/stop injected while busy
    cfg_rdata = 16'h00A5; cfg_rd_to = 2;
    rd0 = n_rd; wr0 = n_wr;
    expect_run(0, 1);
    pulse(1);
    repeat (8) @(negedge clk);
    pulse(1);
    pulse(0);
    wait_idle();
    chk(exp_q.size() == 0 && done, "R2", "pulses during busy ignored", exp_q.size(), 0);
    chk(!psel && osc && iso, "R3", "oscillator path {sel,osc,iso}", {psel, osc, iso}, 3'b011);
    chk(n_rd - rd0 == 3 && n_wr - wr0 == 1, "R9", "reads*16+writes after 2 timeouts",
        (n_rd - rd0) * 16 + (n_wr - wr0), 49);
    chk(last_wdata == 16'h03E5, "R9", "write-back after retries", last_wdata, 16'h03E5);

    // S5: restart from done, every read times out
    cfg_rd_to = 3;
    rd0 = n_rd; wr0 = n_wr;
    expect_run(0, 0);
    pulse(1);
    wait_idle();
    chk(n_rd - rd0 == 3 && n_wr - wr0 == 0, "R9", "reads*16+writes when all reads time out",
        (n_rd - rd0) * 16 + (n_wr - wr0), 48);
    chk(err && !done, "R9", "error after exhausted retries", {err, done}, 2'b10);

    // S6: stop from error keeps error; stop while idle ignored
    expect_stop();
    pulse(0);
    wait_idle();
    chk(err, "R12", "error held through stop", err, 1);
    chk(!osc && !u3_rel, "R11", "oscillator shutdown", {osc, u3_rel}, 0);
    pulse(0);
    repeat (10) @(negedge clk);
    chk(dut_snap() == prev && !busy, "R11", "stop while idle", 32'(dut_snap()), 32'(prev));

    // S7: bus error on read
    cfg_rd_to = 0; cfg_rd_err = 1;
    rd0 = n_rd; wr0 = n_wr;
    expect_run(0, 0);
    pulse(1);
    repeat (2) @(negedge clk);
    chk(!err && busy, "R12", "error cleared by start", {err, busy}, 2'b01);
    wait_idle();
    chk(n_rd - rd0 == 1 && n_wr - wr0 == 0 && err, "R10", "abort on read error",
        (n_rd - rd0) * 16 + (n_wr - wr0), 16);

    // S8: write timeout from error state
    cfg_rd_err = 0; cfg_wr_to = 1;
    rd0 = n_rd; wr0 = n_wr;
    expect_run(0, 0);
    pulse(1);
    wait_idle();
    chk(n_rd - rd0 == 1 && n_wr - wr0 == 1 && err && !bus_req, "R10", "abort on write timeout",
        (n_rd - rd0) * 16 + (n_wr - wr0), 17);

    // S9: read value already holding level bits
    cfg_wr_to = 0; cfg_rdata = 16'h01C0;
    expect_run(0, 1);
    pulse(1);
    wait_idle();
    chk(last_wdata == 16'h03C0 && done, "R8", "OR into existing bits", last_wdata, 16'h03C0);
    chk(exp_q.size() == 0, "R4", "all expected steps seen", exp_q.size(), 0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL R2 watchdog expired: got busy=%0b expected 0", busy);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule